// File: doc/BRIEF.md
# Eight-Bit Arithmetic Logic Unit with Complement Subtraction

This block is a purely combinational 8-bit arithmetic logic unit. Two operands, a carry-in and a 3-bit operation code go in; an 8-bit result and four status flags come out: carry, overflow, negative and zero. Any change on an input reaches the outputs in the same evaluation, with no clock inside the block.

Addition and subtraction share one ripple adder. To subtract, the second operand passes through a selectable ones' complementor, and the adder's carry-in is either forced or taken from the carry-in pin. The block has no two's-complement negator of its own. A compare operation leaves the first operand on the result bus. During compare, the zero and carry flags are switched, through two 2:1 selectors, to an equality signal and an unsigned greater-than signal.

An update-enable vector marks the flags that each operation affects. A flag register outside the block uses it to hold the flags an operation leaves alone.

Top module: `alu8_core`

## Requirements
- R1: Operation codes are 3'b000 add, 3'b001 add-with-carry, 3'b010 subtract, 3'b011 subtract-with-borrow, 3'b100 AND, 3'b101 OR, 3'b110 XOR and 3'b111 compare. For AND, OR and XOR the result is the bitwise function of A and B.
- R2: Add gives F = (A + B) mod 256 and carry = bit 8 of A + B. The carry-in pin has no effect on add.
- R3: Add-with-carry gives F = (A + B + CI) mod 256, with carry = bit 8 of that sum.
- R4: Subtract gives F = (A + NOT B + 1) mod 256, with carry = bit 8 of that sum. Carry is therefore 1 exactly when A >= B unsigned (no borrow), and the carry-in pin has no effect.
- R5: Subtract-with-borrow gives F = (A + NOT B + CI) mod 256, with carry = bit 8. CI = 1 means no borrow is pending.
- R6: For the four arithmetic operations, overflow is 1 exactly when A and the adder's second operand (B, or NOT B when subtracting) have equal sign bits and F has a different sign bit.
- R7: The negative flag equals F[7] for every operation.
- R8: For the arithmetic and bitwise operations, the zero flag is 1 exactly when F is all zeros.
- R9: Compare gives F = A, zero = (A == B), carry = (A > B unsigned) and overflow = 0.
- R10: The update-enable output uses the layout bit 3 carry, bit 2 overflow, bit 1 negative, bit 0 zero. It is 4'b1111 for the arithmetic operations, 4'b0011 for AND, OR and XOR, and 4'b1001 for compare.
- R11: For AND, OR and XOR, carry and overflow are 0 and the carry-in pin has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 8 | First operand |
| b_i | input | 8 | Second operand |
| ci_i | input | 1 | Carry-in; during subtraction, 1 means no borrow |
| op_i | input | 3 | Operation code |
| f_o | output | 8 | Result |
| co_o | output | 1 | Carry flag (greater-than during compare) |
| ov_o | output | 1 | Signed overflow flag |
| neg_o | output | 1 | Negative flag |
| zero_o | output | 1 | Zero flag (equality during compare) |
| flag_upd_o | output | 4 | Per-flag update enables {carry, overflow, negative, zero} |

## Verification
The bench drives values at the signed and unsigned boundaries: 0x7F + 1, 0x80 + 0x80, 0xFF + 1, 0x80 - 1 and 0 - 1. A block that took overflow from the wrong carries, or inverted the borrow sense, would report the wrong flags on these cases. It also sets the carry-in on add, subtract and the bitwise operations. A block that forwarded the pin where the carry should be forced would give a result that is off by one. For compare it applies equal, greater and smaller operands. A block that left the adder's zero or carry on the flag selectors would report the flags of a subtraction rather than equality and unsigned order. Randomised operations then cover the update-enable mask and the negative flag for every operation code.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    typedef enum logic [2:0] {
        OP_ADD  = 3'b000,
        OP_ADDC = 3'b001,
        OP_SUB  = 3'b010,
        OP_SUBC = 3'b011,
        OP_AND  = 3'b100,
        OP_OR   = 3'b101,
        OP_XOR  = 3'b110,
        OP_CMP  = 3'b111
    } alu_op_e;

    typedef struct packed {
        logic co;
        logic ov;
        logic neg;
        logic zero;
    } alu_flags_t;

    typedef enum logic [1:0] {
        CSEL_ZERO = 2'd0,
        CSEL_ONE  = 2'd1,
        CSEL_PIN  = 2'd2
    } carry_sel_e;

    function automatic logic op_is_arith(alu_op_e op);
        return (op == OP_ADD) || (op == OP_ADDC) || (op == OP_SUB) || (op == OP_SUBC);
    endfunction

    function automatic logic op_is_bitwise(alu_op_e op);
        return (op == OP_AND) || (op == OP_OR) || (op == OP_XOR);
    endfunction

    function automatic logic op_is_sub(alu_op_e op);
        return (op == OP_SUB) || (op == OP_SUBC);
    endfunction

    function automatic carry_sel_e op_carry_sel(alu_op_e op);
        case (op)
            OP_SUB:           return CSEL_ONE;
            OP_ADDC, OP_SUBC: return CSEL_PIN;
            default:          return CSEL_ZERO;
        endcase
    endfunction

    function automatic alu_flags_t op_update_mask(alu_op_e op);
        alu_flags_t m;
        if (op_is_arith(op))        m = '{co: 1'b1, ov: 1'b1, neg: 1'b1, zero: 1'b1};
        else if (op == OP_CMP)      m = '{co: 1'b1, ov: 1'b0, neg: 1'b0, zero: 1'b1};
        else                        m = '{co: 1'b0, ov: 1'b0, neg: 1'b1, zero: 1'b1};
        return m;
    endfunction

endpackage

// File: rtl/alu8_operand_cond.sv
module alu8_operand_cond
    import alu8_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] b_i,
    input  logic             ci_i,
    input  alu_op_e          op_i,
    output logic [WIDTH-1:0] b_eff_o,
    output logic             cin_o
);
    logic       invert;
    carry_sel_e csel;

    always_comb begin
        invert  = op_is_sub(op_i);
        csel    = op_carry_sel(op_i);
        b_eff_o = invert ? ~b_i : b_i;
        case (csel)
            CSEL_ONE: cin_o = 1'b1;
            CSEL_PIN: cin_o = ci_i;
            default:  cin_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/alu8_ripple_adder.sv
module alu8_ripple_adder #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             cout_o,
    output logic             ov_o
);
    logic [WIDTH:0] carry;

    assign carry[0] = cin_i;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign sum_o[i]   = a_i[i] ^ b_i[i] ^ carry[i];
        assign carry[i+1] = (a_i[i] & b_i[i]) | (carry[i] & (a_i[i] ^ b_i[i]));
    end

    assign cout_o = carry[WIDTH];
    assign ov_o   = carry[WIDTH] ^ carry[WIDTH-1];
endmodule

// File: rtl/alu8_logic_unit.sv
module alu8_logic_unit
    import alu8_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  alu_op_e          op_i,
    output logic [WIDTH-1:0] res_o
);
    always_comb begin
        case (op_i)
            OP_AND:  res_o = a_i & b_i;
            OP_OR:   res_o = a_i | b_i;
            OP_XOR:  res_o = a_i ^ b_i;
            default: res_o = a_i;
        endcase
    end
endmodule

// File: rtl/alu8_compare.sv
module alu8_compare #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic             eq_o,
    output logic             gt_o
);
    assign eq_o = (a_i == b_i);
    assign gt_o = (a_i > b_i);
endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             ci_i,
    input  logic [2:0]       op_i,
    output logic [WIDTH-1:0] f_o,
    output logic             co_o,
    output logic             ov_o,
    output logic             neg_o,
    output logic             zero_o,
    output logic [3:0]       flag_upd_o
);
    localparam int MSB = WIDTH - 1;

    alu_op_e          op;
    logic [WIDTH-1:0] b_eff;
    logic             cin;
    logic [WIDTH-1:0] sum;
    logic             add_co;
    logic             add_ov;
    logic [WIDTH-1:0] logic_res;
    logic             a_eq_b;
    logic             a_gt_b;
    logic             res_zero;
    alu_flags_t       flags;
    alu_flags_t       upd;

    assign op = alu_op_e'(op_i);

    alu8_operand_cond #(.WIDTH(WIDTH)) u_cond (
        .b_i     (b_i),
        .ci_i    (ci_i),
        .op_i    (op),
        .b_eff_o (b_eff),
        .cin_o   (cin)
    );

    alu8_ripple_adder #(.WIDTH(WIDTH)) u_adder (
        .a_i    (a_i),
        .b_i    (b_eff),
        .cin_i  (cin),
        .sum_o  (sum),
        .cout_o (add_co),
        .ov_o   (add_ov)
    );

    alu8_logic_unit #(.WIDTH(WIDTH)) u_logic (
        .a_i   (a_i),
        .b_i   (b_i),
        .op_i  (op),
        .res_o (logic_res)
    );

    alu8_compare #(.WIDTH(WIDTH)) u_cmp (
        .a_i  (a_i),
        .b_i  (b_i),
        .eq_o (a_eq_b),
        .gt_o (a_gt_b)
    );

    always_comb begin
        f_o        = op_is_arith(op) ? sum : logic_res;
        res_zero   = ~|f_o;
        flags.neg  = f_o[MSB];
        flags.zero = (op == OP_CMP) ? a_eq_b : res_zero;
        flags.co   = (op == OP_CMP) ? a_gt_b : (op_is_arith(op) & add_co);
        flags.ov   = op_is_arith(op) & add_ov;
        upd        = op_update_mask(op);
    end

    assign co_o       = flags.co;
    assign ov_o       = flags.ov;
    assign neg_o      = flags.neg;
    assign zero_o     = flags.zero;
    assign flag_upd_o = upd;

    always_comb begin
        if (op == OP_ADD)
            AST_ADD_SUM: assert ({co_o, f_o} == ({1'b0, a_i} + {1'b0, b_i})); // R2
        if (op == OP_SUB)
            AST_SUB_NO_BORROW: assert (co_o == (a_i >= b_i)); // R4
        if (op == OP_CMP)
            AST_CMP_PASS_A: assert (f_o == a_i && !ov_o); // R9
        if (op_is_bitwise(op))
            AST_BITWISE_NO_ARITH_FLAGS: assert (!co_o && !ov_o); // R11
        if (op_is_bitwise(op))
            AST_BITWISE_MASK: assert (flag_upd_o == 4'b0011); // R10
    end
endmodule

// File: tb/alu8_core_tb_top.sv
module alu8_core_tb_top;

    typedef struct {
        logic [7:0] f;
        logic       co;
        logic       ov;
        logic       neg;
        logic       zero;
        logic [3:0] upd;
        logic [2:0] op;
        string      tag_f;
        string      tag_co;
        string      tag_ov;
        string      tag_z;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] a = '0;
    logic [7:0] b = '0;
    logic       ci = 1'b0;
    logic [2:0] op = 3'b000;
    logic [7:0] f;
    logic       co, ov, neg, zero;
    logic [3:0] upd;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    exp_t sb_q[$];

    always #4 clk = ~clk;

    alu8_core dut_i (
        .a_i        (a),
        .b_i        (b),
        .ci_i       (ci),
        .op_i       (op),
        .f_o        (f),
        .co_o       (co),
        .ov_o       (ov),
        .neg_o      (neg),
        .zero_o     (zero),
        .flag_upd_o (upd)
    );

    function automatic exp_t model(logic [7:0] av, logic [7:0] bv, logic civ, logic [2:0] opv);
        exp_t       e;
        logic [7:0] bb;
        logic       c;
        logic [8:0] s;
        e.op = opv;
        e.co = 1'b0; e.ov = 1'b0;
        if (opv <= 3'b011) begin
            bb = opv[1] ? ~bv : bv;
            c  = (opv == 3'b000) ? 1'b0 : (opv == 3'b010) ? 1'b1 : civ;
            s  = {1'b0, av} + {1'b0, bb} + {8'b0, c};
            e.f  = s[7:0];
            e.co = s[8];
            e.ov = (av[7] == bb[7]) && (s[7] != av[7]);
            e.zero = (s[7:0] == 8'h00);
            e.upd  = 4'b1111;
            e.tag_f  = (opv == 3'b000) ? "R2" : (opv == 3'b001) ? "R3" : (opv == 3'b010) ? "R4" : "R5";
            e.tag_co = e.tag_f;
            e.tag_ov = "R6";
            e.tag_z  = "R8";
        end else if (opv == 3'b111) begin
            e.f    = av;
            e.co   = av > bv;
            e.zero = av == bv;
            e.upd  = 4'b1001;
            e.tag_f = "R9"; e.tag_co = "R9"; e.tag_ov = "R9"; e.tag_z = "R9";
        end else begin
            e.f = (opv == 3'b100) ? (av & bv) : (opv == 3'b101) ? (av | bv) : (av ^ bv);
            e.zero = (e.f == 8'h00);
            e.upd  = 4'b0011;
            e.tag_f = "R1"; e.tag_co = "R11"; e.tag_ov = "R11"; e.tag_z = "R8";
        end
        e.neg = e.f[7];
        return e;
    endfunction

    task automatic drive(logic [7:0] av, logic [7:0] bv, logic civ, logic [2:0] opv);
        @(posedge clk);
        a = av; b = bv; ci = civ; op = opv;
        sb_q.push_back(model(av, bv, civ, opv));
    endtask

    task automatic cmp(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h (op %0d a %0h b %0h ci %0b)",
                     tag, what, act, exp, op, a, b, ci);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            cmp(e.tag_f,  "F",   f,    e.f);
            cmp(e.tag_co, "CO",  co,   e.co);
            cmp(e.tag_ov, "O",   ov,   e.ov);
            cmp("R7",     "N",   neg,  e.neg);
            cmp(e.tag_z,  "Z",   zero, e.zero);
            cmp("R10",    "UPD", upd,  e.upd);
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // reset state: all-zero inputs perform ADD 0+0
        drive(8'h00, 8'h00, 1'b0, 3'b000);
        // R2: carry-in ignored on add, carry out, overflow corners (R6)
        drive(8'h7F, 8'h01, 1'b1, 3'b000);
        drive(8'h80, 8'h80, 1'b0, 3'b000);
        drive(8'hFF, 8'h01, 1'b0, 3'b000);
        // R3: add with carry
        drive(8'hFF, 8'h00, 1'b1, 3'b001);
        drive(8'h7F, 8'h00, 1'b1, 3'b001);
        // R4: subtract, pin ignored, borrow sense
        drive(8'h05, 8'h03, 1'b0, 3'b010);
        drive(8'h03, 8'h05, 1'b0, 3'b010);
        drive(8'h80, 8'h01, 1'b0, 3'b010);
        drive(8'h00, 8'h01, 1'b1, 3'b010);
        drive(8'h42, 8'h42, 1'b0, 3'b010);
        // R5: subtract with borrow
        drive(8'h05, 8'h03, 1'b0, 3'b011);
        drive(8'h05, 8'h03, 1'b1, 3'b011);
        drive(8'h00, 8'h00, 1'b0, 3'b011);
        // R1 / R11: bitwise with carry-in set
        drive(8'hF0, 8'h0F, 1'b1, 3'b100);
        drive(8'hF0, 8'h0F, 1'b1, 3'b101);
        drive(8'hAA, 8'hAA, 1'b1, 3'b110);
        // R9: compare equal, greater, smaller
        drive(8'h33, 8'h33, 1'b0, 3'b111);
        drive(8'h90, 8'h10, 1'b1, 3'b111);
        drive(8'h10, 8'h90, 1'b0, 3'b111);
        drive(8'h00, 8'hFF, 1'b0, 3'b111);
        for (int i = 0; i < 400; i++)
            drive(8'($urandom), 8'($urandom), 1'($urandom), 3'($urandom));
        @(posedge clk);
        @(posedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule